// File: doc/BRIEF.md
# Address-Keyed Dependency Tracking Table

This block is one partition of a distributed task dependency tracker. Task parameters arrive one at a time, each with a task id, a 48-bit memory address, a flag that marks the task's last parameter, and a flag that marks a task with exactly one parameter in total. Each address is looked up in a small set-associative table. A resident address owns a list of tasks that are waiting for it to be released.

When an insert hits a resident address, the task is appended to that address's waiter list. When it misses, a way is allocated for the address. A single-parameter task that misses has no dependencies, so its id goes straight to the ready output. Every other insert yields a partial dependence record (task id, local count 0 or 1, last flag), which a downstream gather stage sums across partitions.

Finish events arrive on their own channel. A finish on a resident address streams every waiter out, oldest first, and then frees the way. An insert that finds its set full, or its waiter list full, waits inside the block until a finish frees room. Finishes are always accepted and served first while an insert waits, so this wait cannot deadlock.

Top module: `addr_dep_table`

## Requirements
- R1: After reset, `rdy_valid`, `dc_valid` and `wt_valid` are 0, and `in_ready` and `fin_ready` are 1.
- R2: The set is `addr[SET_W-1:0]` (bits 1:0 by default). A hit requires all 48 address bits to match, so two addresses that share low bits but differ in high bits occupy separate ways.
- R3: An insert with `in_solo`=1 whose address is absent allocates a way and emits its task id on the ready output.
- R4: An insert whose address is resident appends the task to the tail of that address's waiter list. It emits a dependence record with `dc_cnt`=1 and `dc_last` equal to `in_last`.
- R5: An insert with `in_solo`=0 whose address is absent allocates a way and emits a dependence record with `dc_cnt`=0 and `dc_last` equal to `in_last`.
- R6: A finish on a resident address emits every waiter's task id on the waiting output in arrival order, then frees the way. A later insert of that address is treated as absent.
- R7: A finish on an absent address produces no output and changes no table state.
- R8: An insert whose address is absent, and whose set has all 4 ways valid, waits with no output and holds `in_ready` at 0. It proceeds only after a finish frees a way in that set.
- R9: While an insert waits, the finish channel is still accepted and served. A pending finish is served before a pending insert.
- R10: An insert to a resident address whose waiter list already holds 8 tasks waits until a finish on that address.
- R11: Each output holds its valid high and its data unchanged until its ready is seen high.
- R12: Each accepted insert yields exactly one record, either ready or dependence. At most one of the three output valids is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Insert entry valid |
| in_ready | output | 1 | Insert entry accepted when high with in_valid |
| in_tid | input | 8 | Task id of the parameter |
| in_addr | input | 48 | Parameter address |
| in_last | input | 1 | Last parameter of its task |
| in_solo | input | 1 | Task has exactly one parameter |
| fin_valid | input | 1 | Finish event valid |
| fin_ready | output | 1 | Finish event accepted |
| fin_addr | input | 48 | Address released by a finished task |
| rdy_valid | output | 1 | Ready task record valid |
| rdy_ready | input | 1 | Ready record consumed |
| rdy_tid | output | 8 | Ready task id |
| dc_valid | output | 1 | Dependence record valid |
| dc_ready | input | 1 | Dependence record consumed |
| dc_tid | output | 8 | Task id of the record |
| dc_cnt | output | 1 | Local dependence count (0 or 1) |
| dc_last | output | 1 | Copy of the last-parameter flag |
| wt_valid | output | 1 | Released waiter valid |
| wt_ready | input | 1 | Released waiter consumed |
| wt_tid | output | 8 | Released waiter task id |

## Verification
The bench fills one set with four addresses and sends a fifth. A design that ignored the full set would overwrite a live way or emit a record it has no room for. The bench also fills one waiter list to eight tasks and sends a ninth. A design that ignored the full list would wrap and corrupt the oldest waiter. Both waits are then cleared by a finish that arrives while the insert is stuck, which exposes a design that blocks finishes behind a waiting insert.

Two addresses that differ only in their high bits check that the tag compare covers every address bit; a partial compare would report a false dependency. Releasing waiters checks their order, and a reinsert after the release checks that the way was really freed. Each output is also held back for several cycles to catch data or valid changing before the handshake completes.

// File: rtl/addr_dep_table.sv
module addr_dep_table #(
  parameter int TID_W  = 8,
  parameter int ADDR_W = 48,
  parameter int SET_W  = 2,
  parameter int WAYS   = 4,
  parameter int LIST_D = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TID_W-1:0]  in_tid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_last,
  input  logic              in_solo,
  input  logic              fin_valid,
  output logic              fin_ready,
  input  logic [ADDR_W-1:0] fin_addr,
  output logic              rdy_valid,
  input  logic              rdy_ready,
  output logic [TID_W-1:0]  rdy_tid,
  output logic              dc_valid,
  input  logic              dc_ready,
  output logic [TID_W-1:0]  dc_tid,
  output logic              dc_cnt,
  output logic              dc_last,
  output logic              wt_valid,
  input  logic              wt_ready,
  output logic [TID_W-1:0]  wt_tid
);
  localparam int SETS   = 1 << SET_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int LIDX_W = (LIST_D > 1) ? $clog2(LIST_D) : 1;
  localparam int CNT_W  = $clog2(LIST_D + 1);

  typedef enum logic [1:0] {S_IDLE, S_EMIT, S_DRAIN} state_t;
  state_t st;

  logic [ADDR_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q [SETS];
  logic [CNT_W-1:0]  cnt_q [SETS][WAYS];
  logic [TID_W-1:0]  lst_q [SETS][WAYS][LIST_D];

  logic              ins_v, ins_last, ins_solo, fin_v;
  logic [TID_W-1:0]  ins_tid;
  logic [ADDR_W-1:0] ins_a, fin_a;
  logic [SET_W-1:0]  ds;
  logic [WAY_W-1:0]  dw;
  logic [CNT_W-1:0]  di;

  wire [ADDR_W-1:0] key = fin_v ? fin_a : ins_a;
  wire [SET_W-1:0]  set = key[SET_W-1:0];

  logic             hit, free;
  logic [WAY_W-1:0] hway, fway;
  always_comb begin
    hit = 1'b0; free = 1'b0; hway = '0; fway = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[set][w] && tag_q[set][w] == key) begin hit = 1'b1; hway = WAY_W'(w); end
      if (!vld_q[set][w]) begin free = 1'b1; fway = WAY_W'(w); end
    end
  end

  wire [CNT_W-1:0] hcnt  = cnt_q[set][hway];
  wire             lfull = (hcnt == CNT_W'(LIST_D));

  assign in_ready  = !ins_v;
  assign fin_ready = !fin_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ins_v <= 1'b0; fin_v <= 1'b0;
      rdy_valid <= 1'b0; dc_valid <= 1'b0; wt_valid <= 1'b0;
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      if (in_valid && in_ready) begin
        ins_v <= 1'b1; ins_tid <= in_tid; ins_a <= in_addr;
        ins_last <= in_last; ins_solo <= in_solo;
      end
      if (fin_valid && fin_ready) begin fin_v <= 1'b1; fin_a <= fin_addr; end
      case (st)
        S_IDLE:
          if (fin_v) begin
            if (hit) begin ds <= set; dw <= hway; di <= '0; st <= S_DRAIN; end
            else fin_v <= 1'b0;
          end else if (ins_v) begin
            if (hit && !lfull) begin
              lst_q[set][hway][hcnt[LIDX_W-1:0]] <= ins_tid;
              cnt_q[set][hway] <= hcnt + CNT_W'(1);
              dc_valid <= 1'b1; dc_tid <= ins_tid; dc_cnt <= 1'b1; dc_last <= ins_last;
              st <= S_EMIT;
            end else if (!hit && free) begin
              vld_q[set][fway] <= 1'b1; tag_q[set][fway] <= ins_a; cnt_q[set][fway] <= '0;
              if (ins_solo) begin rdy_valid <= 1'b1; rdy_tid <= ins_tid; end
              else begin dc_valid <= 1'b1; dc_tid <= ins_tid; dc_cnt <= 1'b0; dc_last <= ins_last; end
              st <= S_EMIT;
            end
          end
        S_EMIT:
          if ((rdy_valid && rdy_ready) || (dc_valid && dc_ready)) begin
            rdy_valid <= 1'b0; dc_valid <= 1'b0; ins_v <= 1'b0; st <= S_IDLE;
          end
        S_DRAIN:
          if (!wt_valid) begin
            if (di == cnt_q[ds][dw]) begin
              vld_q[ds][dw] <= 1'b0; fin_v <= 1'b0; st <= S_IDLE;
            end else begin
              wt_valid <= 1'b1; wt_tid <= lst_q[ds][dw][di[LIDX_W-1:0]]; di <= di + CNT_W'(1);
            end
          end else if (wt_ready) wt_valid <= 1'b0;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/addr_dep_table_chk.sv
module addr_dep_table_chk #(
  parameter int TID_W = 8
)(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             fin_valid,
  input logic             fin_ready,
  input logic             rdy_valid,
  input logic             rdy_ready,
  input logic [TID_W-1:0] rdy_tid,
  input logic             dc_valid,
  input logic             dc_ready,
  input logic [TID_W-1:0] dc_tid,
  input logic             dc_cnt,
  input logic             dc_last,
  input logic             wt_valid,
  input logic             wt_ready,
  input logic [TID_W-1:0] wt_tid
);
  assert_rdy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_valid && !rdy_ready |=> rdy_valid && $stable(rdy_tid));
  assert_dc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dc_valid && !dc_ready |=> dc_valid && $stable({dc_tid, dc_cnt, dc_last}));
  assert_wt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wt_valid && !wt_ready |=> wt_valid && $stable(wt_tid));
  assert_one_out_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rdy_valid, dc_valid, wt_valid}));
  assert_ins_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);
  assert_fin_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fin_valid && fin_ready |=> !fin_ready);
endmodule

bind addr_dep_table addr_dep_table_chk #(.TID_W(TID_W)) chk_i (.*);

// File: tb/addr_dep_table_tb_top.sv
`timescale 1ns/1ps
module addr_dep_table_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_last = 0, in_solo = 0, fin_valid = 0;
  logic rdy_ready = 1, dc_ready = 1, wt_ready = 1;
  logic [7:0] in_tid = 0;
  logic [47:0] in_addr = 0, fin_addr = 0;
  logic in_ready, fin_ready, rdy_valid, dc_valid, wt_valid, dc_cnt, dc_last;
  logic [7:0] rdy_tid, dc_tid, wt_tid;
  int nchk = 0, nfail = 0;
  int rq[$], dq[$], wq[$];

  always #2 clk = ~clk;

  addr_dep_table dut_i (.*);

  always @(posedge clk) begin
    if (rdy_valid && rdy_ready) rq.push_back(int'(rdy_tid));
    if (dc_valid && dc_ready) dq.push_back(int'(dc_tid) * 4 + int'(dc_cnt) * 2 + int'(dc_last));
    if (wt_valid && wt_ready) wq.push_back(int'(wt_tid));
  end

  function automatic logic [47:0] af(int k);
    return {8'(k), 38'h0, 2'(k)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic send_ins(int tid, int k, bit last, bit solo);
    @(negedge clk);
    in_valid = 1; in_tid = 8'(tid); in_addr = af(k); in_last = last; in_solo = solo;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send_fin(int k);
    @(negedge clk);
    fin_valid = 1; fin_addr = af(k);
    while (!fin_ready) @(negedge clk);
    @(negedge clk);
    fin_valid = 0;
  endtask

  task automatic wait_q(ref int q[$]);
    for (int n = 0; n < 100 && q.size() == 0; n++) @(negedge clk);
  endtask

  task automatic exp_rdy(int tid, string req);
    int v;
    wait_q(rq);
    v = (rq.size() > 0) ? rq.pop_front() : -1;
    chk(v == tid, req, v, tid);
  endtask

  task automatic exp_dc(int tid, int cnt, int last, string req);
    int v, e;
    e = tid * 4 + cnt * 2 + last;
    wait_q(dq);
    v = (dq.size() > 0) ? dq.pop_front() : -1;
    chk(v == e, req, v, e);
  endtask

  task automatic exp_wt(int tid, string req);
    int v;
    wait_q(wq);
    v = (wq.size() > 0) ? wq.pop_front() : -1;
    chk(v == tid, req, v, tid);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({rdy_valid, dc_valid, wt_valid} == 3'b000, "R1 valids", int'({rdy_valid, dc_valid, wt_valid}), 0);
    chk(in_ready && fin_ready, "R1 readies", int'({in_ready, fin_ready}), 3);

    send_ins(1, 1, 1, 1); exp_rdy(1, "R3 solo miss");
    send_ins(2, 1, 1, 1); exp_dc(2, 1, 1, "R4 hit appends");
    send_ins(3, 2, 0, 0); exp_dc(3, 0, 0, "R5 miss non-solo");
    send_ins(3, 1, 1, 0); exp_dc(3, 1, 1, "R4 second waiter");
    send_fin(1); exp_wt(2, "R6 first waiter"); exp_wt(3, "R6 second waiter");
    send_ins(4, 1, 1, 1); exp_rdy(4, "R6 entry freed");
    send_fin(6); idle(20);
    chk(wq.size() == 0 && rq.size() == 0 && dq.size() == 0, "R7 absent finish", wq.size(), 0);
    send_ins(5, 5, 1, 1); exp_rdy(5, "R2 high bits differ");
    send_ins(6, 6, 1, 0); exp_dc(6, 0, 1, "R7 no entry left");

    for (int i = 0; i < 4; i++) begin
      send_ins(10 + i, 4 * i, 1, 1); exp_rdy(10 + i, "R2 fill set 0");
    end
    send_ins(14, 16, 1, 1); idle(30);
    chk(rq.size() == 0 && dq.size() == 0, "R8 full set stalls", rq.size() + dq.size(), 0);
    chk(!in_ready, "R8 in_ready low", int'(in_ready), 0);
    send_fin(8); exp_rdy(14, "R9 finish while stalled");

    for (int i = 0; i < 8; i++) begin
      send_ins(20 + i, 2, 1, 0); exp_dc(20 + i, 1, 1, "R4 fill list");
    end
    send_ins(28, 2, 1, 1); idle(30);
    chk(rq.size() == 0 && dq.size() == 0, "R10 full list stalls", rq.size() + dq.size(), 0);
    send_fin(2);
    for (int i = 0; i < 8; i++) exp_wt(20 + i, "R6 order after full list");
    exp_rdy(28, "R10 resumes after finish");

    rdy_ready = 0;
    send_ins(30, 3, 1, 1); idle(10);
    chk(rdy_valid && rq.size() == 0, "R11 rdy held", int'(rdy_valid), 1);
    rdy_ready = 1; exp_rdy(30, "R11 rdy after release");
    dc_ready = 0;
    send_ins(31, 3, 1, 0); idle(10);
    chk(dc_valid && dq.size() == 0, "R11 dc held", int'(dc_valid), 1);
    dc_ready = 1; exp_dc(31, 1, 1, "R11 dc after release");
    wt_ready = 0;
    send_fin(3); idle(10);
    chk(wt_valid && wq.size() == 0, "R11 wt held", int'(wt_valid), 1);
    wt_ready = 1; exp_wt(31, "R11 wt after release");

    idle(20);
    chk(rq.size() + dq.size() + wq.size() == 0, "R12 no extra records", rq.size() + dq.size() + wq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule